// File: doc/BRIEF.md
# Slot-Reservation Synchronous Bus Arbiter

This block decides which device owns each time slot of a shared synchronous bus. Time is divided into slots of a fixed number of clock cycles. Sixteen devices each own one request line. A device reserves the following slot by raising its line during the current slot. On the last clock of every slot, the arbiter looks at all reservations collected during that slot. The reserving device with the smallest line number receives the next slot.

A seventeenth device has no request line on the shared bus. It presents a local pending flag instead, and it is given the next slot only when no line was reserved. The decision is held as a one-hot grant with a valid flag for the whole of the following slot. The arbiter drives a slot-end strobe so that every device can align to the slot grid.

A reservation lasts for one slot only. A device that loses must raise its line again in the next slot.

Top module: `slot_arbiter`

## Requirements
- R1: Asserting `xfer_req[i]` in any cycle of a slot, even a single cycle, reserves the next slot for line i. The request is latched until that slot's final clock.
- R2: When several lines are reserved in the same slot, the lowest line number wins. Line 0 outranks every other device.
- R3: `grant` and `grant_valid` change only on the clock edge that ends a slot, and they hold their value for every cycle of the following slot.
- R4: A slot lasts `SLOT_CYCLES` clocks. `slot_end` is high in the last cycle of each slot only. The first slot begins in the cycle in which reset is released.
- R5: Grant bit `NUM_LINES` (bit 16 by default) belongs to the device without a request line. That bit is set for the next slot only if `tail_req` was seen during the slot and no line was reserved.
- R6: If neither any line nor `tail_req` was seen during a slot, the next slot has `grant_valid` low and `grant` all zero.
- R7: Reservations are cleared at every slot end. A line that lost and is not asserted again in the next slot is not granted the slot after.
- R8: While `rst` is high, and in the first slot after it, `grant` is zero and `grant_valid` is low.
- R9: `grant` has at most one bit set, and `grant_valid` is high exactly when one bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_req | input | NUM_LINES | Per-line reservation requests; bit 0 has the highest priority |
| tail_req | input | 1 | Pending flag of the device that has no request line |
| slot_end | output | 1 | High in the last cycle of each slot |
| grant | output | NUM_LINES+1 | One-hot owner of the current slot; the top bit is the device without a line |
| grant_valid | output | 1 | The current slot has an owner |

## Verification
The assertions assume that requests are synchronous to `clk` and that a device reasons about ownership only from `grant` as it stands in the current slot. They make no assumption about how long a request is held. The bench changes inputs only at falling edges and aligns each scenario to the slot grid through `slot_end`. The patterns include single-cycle pulses, requests held for the full slot, several lines at once, and quiet slots. This covers both the latch path and the idle path without ever asking the arbiter to tell apart two requests that arrive in the same clock.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int unsigned MAX_LINES = 31;

    // Decision taken at a slot boundary
    typedef struct packed {
        logic        valid;
        logic        tail;
        logic [4:0]  idx;
    } arb_pick_t;

    // Width of a counter that reaches n-1 (at least one bit)
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Expand a decision into a one-hot vector over lines plus the tail device
    function automatic logic [MAX_LINES:0] pick_to_onehot(input arb_pick_t p,
                                                          input int unsigned lines);
        logic [MAX_LINES:0] v;
        v = '0;
        if (p.valid) begin
            if (p.tail) v[lines] = 1'b1;
            else        v[p.idx] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/arb_slot_timer.sv
module arb_slot_timer #(
    parameter int unsigned SLOT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    output logic slot_last
);
    import arb_pkg::*;

    localparam int unsigned CW = cnt_width(SLOT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign slot_last = (cnt_q == LAST);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    generate
        if (SLOT_CYCLES > 1) begin : g_multi
            // R4
            slot_gap_chk: assert property (@(posedge clk) disable iff (rst)
                slot_last |=> !slot_last);
        end
    endgenerate

endmodule

// File: rtl/arb_resv_bank.sv
module arb_resv_bank #(
    parameter int unsigned NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 slot_last,
    input  logic [NUM_LINES-1:0] req,
    input  logic                 tail_req,
    output logic [NUM_LINES-1:0] resv,
    output logic                 tail_resv
);
    logic [NUM_LINES-1:0] pend_q;
    logic                 tail_q;

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst || slot_last) pend_q[i] <= 1'b0;
                else if (req[i])      pend_q[i] <= 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || slot_last) tail_q <= 1'b0;
        else if (tail_req)    tail_q <= 1'b1;
    end

    // Reservation includes the request seen on the boundary clock itself
    assign resv      = pend_q | req;
    assign tail_resv = tail_q | tail_req;

    // R1: a latch bit only sets after its line was seen
    latch_src_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ~$past(pend_q) & ~$past(req)) == '0));

    // R7: latches are empty at the start of each slot
    latch_clear_chk: assert property (@(posedge clk) disable iff (rst)
        slot_last |=> (pend_q == '0 && !tail_q));

endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int unsigned NUM_LINES = 16
) (
    input  logic [NUM_LINES-1:0] resv,
    input  logic                 tail_resv,
    output arb_pkg::arb_pick_t   pick
);
    import arb_pkg::*;

    // blocked[i] is set when some lower-numbered line holds a reservation
    logic [NUM_LINES:0]   blocked;
    logic [NUM_LINES-1:0] win;

    assign blocked[0] = 1'b0;

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_ladder
            assign win[i]       = resv[i] & ~blocked[i];
            assign blocked[i+1] = blocked[i] | resv[i];
        end
    endgenerate

    always_comb begin
        pick       = '0;
        pick.tail  = ~blocked[NUM_LINES] & tail_resv;
        pick.valid = blocked[NUM_LINES] | tail_resv;
        for (int j = 0; j < NUM_LINES; j++) begin
            if (win[j]) pick.idx = 5'(j);
        end
    end

    // R2
    always_comb begin
        single_win_chk: assert ($onehot0(win));
    end

endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter #(
    parameter int unsigned NUM_LINES   = 16,
    parameter int unsigned SLOT_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] xfer_req,
    input  logic                 tail_req,
    output logic                 slot_end,
    output logic [NUM_LINES:0]   grant,
    output logic                 grant_valid
);
    import arb_pkg::*;

    localparam int unsigned GW = NUM_LINES + 1;

    logic [NUM_LINES-1:0] resv;
    logic                 tail_resv;
    arb_pick_t            pick;
    logic [MAX_LINES:0]   pick_vec;
    logic [GW-1:0]        grant_q;
    logic                 valid_q;

    arb_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .slot_last (slot_end)
    );

    arb_resv_bank #(.NUM_LINES(NUM_LINES)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .slot_last (slot_end),
        .req       (xfer_req),
        .tail_req  (tail_req),
        .resv      (resv),
        .tail_resv (tail_resv)
    );

    arb_prio_pick #(.NUM_LINES(NUM_LINES)) u_pick (
        .resv      (resv),
        .tail_resv (tail_resv),
        .pick      (pick)
    );

    assign pick_vec = pick_to_onehot(pick, NUM_LINES);

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            valid_q <= 1'b0;
        end else if (slot_end) begin
            grant_q <= pick_vec[GW-1:0];
            valid_q <= pick.valid;
        end
    end

    assign grant       = grant_q;
    assign grant_valid = valid_q;

    // R9
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q) && (valid_q == ($countones(grant_q) == 1)));

    // R3
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_end |=> ($stable(grant_q) && $stable(valid_q)));

    // R2
    top_line_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_end && resv[0]) |=> grant_q[0]);

    // R5
    tail_win_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_end && resv == '0 && tail_resv) |=> grant_q[NUM_LINES]);

    // R5
    tail_yield_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_end && resv != '0) |=> !grant_q[NUM_LINES]);

    // R6
    idle_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_end && resv == '0 && !tail_resv) |=> !valid_q);

endmodule

// File: tb/slot_arbiter_tb.sv
module slot_arbiter_tb;
    localparam int unsigned NL   = 16;
    localparam int unsigned SLOT = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] xfer_req = '0;
    logic          tail_req = 1'b0;
    logic          slot_end;
    logic [NL:0]   grant;
    logic          grant_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [NL:0] cur_exp = '0;

    always #2 clk = ~clk;

    slot_arbiter #(.NUM_LINES(NL), .SLOT_CYCLES(SLOT)) u_dut (
        .clk(clk), .rst(rst), .xfer_req(xfer_req), .tail_req(tail_req),
        .slot_end(slot_end), .grant(grant), .grant_valid(grant_valid)
    );

    function automatic logic [NL:0] model(input logic [NL-1:0] lines, input logic tail);
        logic [NL:0] g;
        g = '0;
        for (int i = NL - 1; i >= 0; i--) if (lines[i]) g = (NL+1)'(1) << i;
        if (lines == '0 && tail) g[NL] = 1'b1;
        return g;
    endfunction

    task automatic check_grant(input string tag);
        checks++;
        if (grant !== cur_exp || grant_valid !== (cur_exp != '0)) begin
            errors++;
            $display("FAIL %s grant=%h valid=%b expected grant=%h valid=%b",
                     tag, grant, grant_valid, cur_exp, cur_exp != '0);
        end
    endtask

    // Starts at a falling edge in cycle 0 of a slot; ends in cycle 0 of the next
    task automatic run_slot(input logic [NL-1:0] lines, input logic tail,
                            input int hold, input string tag);
        for (int k = 0; k < SLOT; k++) begin
            xfer_req = (k < hold) ? lines : '0;
            tail_req = (k < hold) ? tail  : 1'b0;
            check_grant("R3 hold");
            checks++;
            if (slot_end !== (k == SLOT - 1)) begin
                errors++;
                $display("FAIL R4 slot_end=%b expected %b at cycle %0d",
                         slot_end, k == SLOT - 1, k);
            end
            @(negedge clk);
        end
        xfer_req = '0;
        tail_req = 1'b0;
        cur_exp  = model(lines, tail);
        check_grant(tag);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        cur_exp = '0;
        check_grant("R8 during reset");
        rst = 1'b0;
        check_grant("R8 after release");
    endtask

    task automatic t_single();
        run_slot(16'h0020, 1'b0, SLOT, "R1 single line 5");
    endtask

    task automatic t_pulse();
        run_slot(16'h0200, 1'b0, 1, "R1 one-cycle pulse line 9");
    endtask

    task automatic t_priority();
        run_slot(16'h8C10, 1'b0, SLOT, "R2 lines 4,10,11,15");
        run_slot(16'h8001, 1'b1, 2, "R2 line 0 over 15 and tail");
    endtask

    task automatic t_tail();
        run_slot(16'h8000, 1'b1, SLOT, "R5 line 15 beats tail");
        run_slot(16'h0000, 1'b1, 1, "R5 tail alone");
    endtask

    task automatic t_idle();
        run_slot(16'h0000, 1'b0, SLOT, "R6 idle slot");
    endtask

    task automatic t_drop();
        run_slot(16'h0084, 1'b0, SLOT, "R7 lines 2,7");
        run_slot(16'h0000, 1'b0, SLOT, "R7 loser not renewed");
        run_slot(16'h0080, 1'b0, SLOT, "R7 loser renewed");
        run_slot(16'h0000, 1'b0, SLOT, "R9 back to idle");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_single();
        t_pulse();
        t_priority();
        t_tail();
        t_idle();
        t_drop();
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule